// File: doc/BRIEF.md
# Serial Audio Receive Clock and Frame-Sync Router

This block sits at the front of a serial audio receive port. It decides where the receive bit clock and the receive frame sync come from. The candidates are the local clock generator, the external pins, or the clock and frame sync shared with the transmit side. It also decides whether the two bidirectional pins are driven. In synchronous mode the two pins are not needed for clocking, so each one is reused as a general flag. A flag can be an output driven from a register-side value, or an input read back through a synchronizer.

The chosen bit clock and frame sync are oversampled in the system clock domain through a two-stage synchronizer. Edges of the bit clock then produce single-cycle strobes. A launch strobe tells the downstream shift logic when to present data. A sample strobe captures the frame sync into a registered output. A polarity control swaps which bit-clock edge launches and which edge samples.

Top module: `rxck_route`

## Requirements
- R1: With `pol`=0, a rising edge of the selected bit clock makes `launch_stb` high for exactly one cycle, and a falling edge does the same for `sample_stb`. A level change applied before clock edge N is reflected on the strobe after clock edge N+2 (three rising clock edges).
- R2: With `pol`=1 the roles swap: a falling bit-clock edge gives `launch_stb` and a rising edge gives `sample_stb`, with the same latency.
- R3: `fs_smp` takes the level that the selected frame sync had together with the triggering bit-clock edge, and updates in the same cycle that `sample_stb` is high. In every other cycle it holds its value.
- R4: With `sync_mode`=0 and `ckdir`=1, `int_bclk` is the bit clock, `ck_pin_oe`=1 and `ck_pin_o` follows `int_bclk`.
- R5: With `sync_mode`=0 and `ckdir`=0, `ck_pin_oe`=0 and the bit clock is taken from `ck_pin_i`. Toggling `int_bclk` produces no strobe.
- R6: With `sync_mode`=1 and `ckdir`=1, `ck_pin_oe`=1 and `ck_pin_o` equals `flag0_out`. The bit clock is `tx_bclk`, and toggling `int_bclk` produces no strobe.
- R7: With `sync_mode`=1 and `ckdir`=0, `ck_pin_oe`=0 and `flag0_in` shows `ck_pin_i` after two rising clock edges. In every other mode `flag0_in` reads 0.
- R8: With `sync_mode`=0, `fs_pin_oe` equals `fsdir`. With `fsdir`=1, `fs_pin_o` follows `int_fs` and `int_fs` is the frame sync. With `fsdir`=0, the frame sync comes from `fs_pin_i`.
- R9: With `sync_mode`=1, the frame sync is `tx_fs`. With `fsdir`=1 the frame-sync pin drives `flag1_out` (`fs_pin_oe`=1). With `fsdir`=0 the pin is undriven and `flag1_in` shows `fs_pin_i` after two rising clock edges; otherwise `flag1_in` reads 0.
- R10: Pin enables and pin output values follow control-bit changes with no clock edge in between.
- R11: While `rst_n` is low, and right after it is released, `launch_stb`, `sample_stb`, `fs_smp`, `flag0_in` and `flag1_in` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_mode | input | 1 | 1: share the transmit clock and frame sync, pins become flags |
| ckdir | input | 1 | Clock pin direction, 1 = output |
| fsdir | input | 1 | Frame-sync pin direction, 1 = output |
| pol | input | 1 | Edge polarity select |
| int_bclk | input | 1 | Bit clock from the local generator |
| int_fs | input | 1 | Frame sync from the local generator |
| tx_bclk | input | 1 | Bit clock shared with the transmit side |
| tx_fs | input | 1 | Frame sync shared with the transmit side |
| flag0_out | input | 1 | Register-side output flag on the clock pin |
| flag1_out | input | 1 | Register-side output flag on the frame-sync pin |
| ck_pin_i | input | 1 | Clock pin input buffer |
| ck_pin_o | output | 1 | Clock pin output value |
| ck_pin_oe | output | 1 | Clock pin output enable |
| fs_pin_i | input | 1 | Frame-sync pin input buffer |
| fs_pin_o | output | 1 | Frame-sync pin output value |
| fs_pin_oe | output | 1 | Frame-sync pin output enable |
| flag0_in | output | 1 | Synchronized input flag from the clock pin |
| flag1_in | output | 1 | Synchronized input flag from the frame-sync pin |
| launch_stb | output | 1 | One-cycle pulse on the launching bit-clock edge |
| sample_stb | output | 1 | One-cycle pulse on the sampling bit-clock edge |
| fs_smp | output | 1 | Frame sync captured at the sampling edge |

## Verification
The hardest situation to reach from the ports is a clock source that is not selected, because it changes nothing that is visible directly. Proving it is ignored means watching for the absence of a strobe. The stimulus therefore toggles the unselected generator clock in each mode while a scoreboard is waiting, so that any pulse arriving with an empty queue is reported. Polarity is exercised by pairing each bit-clock edge with a distinct frame-sync level. A swapped launch or sample edge then shows up both as the wrong strobe kind and as the wrong captured level.

// File: rtl/rxck_pkg.sv
package rxck_pkg;

  typedef enum logic [1:0] {
    SRC_LOCAL  = 2'd0,
    SRC_PIN    = 2'd1,
    SRC_SHARED = 2'd2
  } rxck_src_e;

  typedef struct packed {
    logic      ck_oe;
    logic      fs_oe;
    rxck_src_e ck_src;
    rxck_src_e fs_src;
    logic      flag0_rd;
    logic      flag1_rd;
  } rxck_route_t;

  function automatic rxck_route_t rxck_decode(input logic sync_m,
                                              input logic ck_d,
                                              input logic fs_d);
    rxck_route_t r;
    r.ck_oe    = ck_d;
    r.fs_oe    = fs_d;
    r.ck_src   = sync_m ? SRC_SHARED : (ck_d ? SRC_LOCAL : SRC_PIN);
    r.fs_src   = sync_m ? SRC_SHARED : (fs_d ? SRC_LOCAL : SRC_PIN);
    r.flag0_rd = sync_m & ~ck_d;
    r.flag1_rd = sync_m & ~fs_d;
    return r;
  endfunction

endpackage

// File: rtl/rxck_sync.sv
module rxck_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [STAGES-1:0][WIDTH-1:0] stg_d;

  always_comb begin
    stg_d[0] = d;
  end

  genvar gi;
  generate
    for (gi = 1; gi < STAGES; gi++) begin : g_chain
      always_comb begin
        stg_d[gi] = stg_q[gi-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= stg_d;
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/rxck_pin_decode.sv
module rxck_pin_decode
  import rxck_pkg::*;
(
  input  logic        sync_mode,
  input  logic        ckdir,
  input  logic        fsdir,
  input  logic        int_bclk,
  input  logic        int_fs,
  input  logic        tx_bclk,
  input  logic        tx_fs,
  input  logic        flag0_out,
  input  logic        flag1_out,
  input  logic        ck_pin_i,
  input  logic        fs_pin_i,
  output logic        ck_pin_o,
  output logic        ck_pin_oe,
  output logic        fs_pin_o,
  output logic        fs_pin_oe,
  output logic        bclk_sel,
  output logic        fs_sel,
  output logic        flag0_rd,
  output logic        flag1_rd
);

  rxck_route_t route;

  always_comb begin
    route = rxck_decode(sync_mode, ckdir, fsdir);
  end

  // pin drive side
  always_comb begin
    ck_pin_oe = route.ck_oe;
    fs_pin_oe = route.fs_oe;
    ck_pin_o  = sync_mode ? flag0_out : int_bclk;
    fs_pin_o  = sync_mode ? flag1_out : int_fs;
    flag0_rd  = route.flag0_rd;
    flag1_rd  = route.flag1_rd;
  end

  // receive-side source muxes
  always_comb begin
    unique case (route.ck_src)
      SRC_LOCAL:  bclk_sel = int_bclk;
      SRC_PIN:    bclk_sel = ck_pin_i;
      SRC_SHARED: bclk_sel = tx_bclk;
      default:    bclk_sel = 1'b0;
    endcase
    unique case (route.fs_src)
      SRC_LOCAL:  fs_sel = int_fs;
      SRC_PIN:    fs_sel = fs_pin_i;
      SRC_SHARED: fs_sel = tx_fs;
      default:    fs_sel = 1'b0;
    endcase
  end

endmodule

// File: rtl/rxck_edge_gen.sv
module rxck_edge_gen #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pol,
  input  logic bclk_raw,
  input  logic fs_raw,
  output logic launch_stb,
  output logic sample_stb,
  output logic fs_smp
);

  localparam int SW = 2;

  logic [SW-1:0] syn_q;
  logic          bclk_s;
  logic          fs_s;
  logic          bclk_prev_q;
  logic          rise;
  logic          fall;
  logic          launch_d;
  logic          sample_d;
  logic          fs_d;
  logic          prev_en;

  rxck_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({fs_raw, bclk_raw}),
    .q     (syn_q)
  );

  assign bclk_s = syn_q[0];
  assign fs_s   = syn_q[1];

  // next-state
  always_comb begin
    rise     = bclk_s & ~bclk_prev_q;
    fall     = ~bclk_s & bclk_prev_q;
    launch_d = pol ? fall : rise;
    sample_d = pol ? rise : fall;
    fs_d     = sample_d ? fs_s : fs_smp;
    prev_en  = rise | fall;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_prev_q <= 1'b0;
    end else if (prev_en) begin
      bclk_prev_q <= bclk_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      launch_stb <= 1'b0;
      sample_stb <= 1'b0;
      fs_smp     <= 1'b0;
    end else begin
      launch_stb <= launch_d;
      sample_stb <= sample_d;
      fs_smp     <= fs_d;
    end
  end

  // R1 / R2: the two strobes never coincide
  p_strobe_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({launch_stb, sample_stb}));

  // R1: a launch strobe lasts one cycle
  p_launch_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    launch_stb |=> !launch_stb);

  // R2: a sample strobe lasts one cycle
  p_sample_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);

  // R3: captured frame sync moves only together with a sample strobe
  p_fs_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |-> $stable(fs_smp));

endmodule

// File: rtl/rxck_route.sv
module rxck_route #(
  parameter int SYNC_STAGES = 2,
  parameter int FLAG_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_mode,
  input  logic ckdir,
  input  logic fsdir,
  input  logic pol,
  input  logic int_bclk,
  input  logic int_fs,
  input  logic tx_bclk,
  input  logic tx_fs,
  input  logic flag0_out,
  input  logic flag1_out,
  input  logic ck_pin_i,
  output logic ck_pin_o,
  output logic ck_pin_oe,
  input  logic fs_pin_i,
  output logic fs_pin_o,
  output logic fs_pin_oe,
  output logic flag0_in,
  output logic flag1_in,
  output logic launch_stb,
  output logic sample_stb,
  output logic fs_smp
);

  localparam int NFLAG = 2;

  logic             bclk_sel;
  logic             fs_sel;
  logic             flag0_rd;
  logic             flag1_rd;
  logic [NFLAG-1:0] flag_s;

  rxck_pin_decode u_dec (
    .sync_mode (sync_mode),
    .ckdir     (ckdir),
    .fsdir     (fsdir),
    .int_bclk  (int_bclk),
    .int_fs    (int_fs),
    .tx_bclk   (tx_bclk),
    .tx_fs     (tx_fs),
    .flag0_out (flag0_out),
    .flag1_out (flag1_out),
    .ck_pin_i  (ck_pin_i),
    .fs_pin_i  (fs_pin_i),
    .ck_pin_o  (ck_pin_o),
    .ck_pin_oe (ck_pin_oe),
    .fs_pin_o  (fs_pin_o),
    .fs_pin_oe (fs_pin_oe),
    .bclk_sel  (bclk_sel),
    .fs_sel    (fs_sel),
    .flag0_rd  (flag0_rd),
    .flag1_rd  (flag1_rd)
  );

  rxck_sync #(.WIDTH(NFLAG), .STAGES(FLAG_STAGES)) u_flag_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({fs_pin_i, ck_pin_i}),
    .q     (flag_s)
  );

  always_comb begin
    flag0_in = flag0_rd & flag_s[0];
    flag1_in = flag1_rd & flag_s[1];
  end

  rxck_edge_gen #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .pol        (pol),
    .bclk_raw   (bclk_sel),
    .fs_raw     (fs_sel),
    .launch_stb (launch_stb),
    .sample_stb (sample_stb),
    .fs_smp     (fs_smp)
  );

  // R4: local clock drives the pin in asynchronous output mode
  p_ck_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_mode && ckdir) |-> (ck_pin_oe && ck_pin_o == int_bclk));

  // R6: flag 0 drives the clock pin in synchronous output mode
  p_flag0_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && ckdir) |-> (ck_pin_oe && ck_pin_o == flag0_out));

  // R7: input flag 0 reads zero unless the pin is a synchronous input
  p_flag0_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(sync_mode && !ckdir) |-> !flag0_in);

  // R9: flag 1 drives the frame-sync pin in synchronous output mode
  p_flag1_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && fsdir) |-> (fs_pin_oe && fs_pin_o == flag1_out));

  // R5 / R7: clock pin is released whenever it is an input
  p_ck_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ckdir |-> !ck_pin_oe);

endmodule

// File: tb/rxck_route_tb.sv
module rxck_route_tb;

  logic clk = 1'b0;
  logic rst_n;
  logic sync_mode, ckdir, fsdir, pol;
  logic int_bclk, int_fs, tx_bclk, tx_fs;
  logic flag0_out, flag1_out, ck_pin_i, fs_pin_i;
  logic ck_pin_o, ck_pin_oe, fs_pin_o, fs_pin_oe;
  logic flag0_in, flag1_in, launch_stb, sample_stb, fs_smp;

  always #2 clk = ~clk;

  rxck_route u_dut (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .ckdir(ckdir),
    .fsdir(fsdir), .pol(pol), .int_bclk(int_bclk), .int_fs(int_fs),
    .tx_bclk(tx_bclk), .tx_fs(tx_fs), .flag0_out(flag0_out),
    .flag1_out(flag1_out), .ck_pin_i(ck_pin_i), .ck_pin_o(ck_pin_o),
    .ck_pin_oe(ck_pin_oe), .fs_pin_i(fs_pin_i), .fs_pin_o(fs_pin_o),
    .fs_pin_oe(fs_pin_oe), .flag0_in(flag0_in), .flag1_in(flag1_in),
    .launch_stb(launch_stb), .sample_stb(sample_stb), .fs_smp(fs_smp)
  );

  typedef struct {
    logic  is_launch;
    logic  fs_exp;
    int    cyc;
    string req;
  } item_t;

  item_t q_exp[$];
  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  logic  fs_model = 1'b0;
  bit    done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (launch_stb || sample_stb)) begin
      if (q_exp.size() == 0) begin
        chk(0, "R5/R6", "unexpected strobe", {launch_stb, sample_stb}, 0);
      end else begin
        item_t it;
        it = q_exp.pop_front();
        chk(launch_stb == it.is_launch, it.req, "strobe kind launch",
            launch_stb, it.is_launch);
        chk(cyc == it.cyc + 3, it.req, "strobe latency", cyc - it.cyc, 3);
        chk(fs_smp == it.fs_exp, "R3", "fs_smp", fs_smp, it.fs_exp);
      end
    end
  end

  // driver: src 0 local, 1 pin, 2 shared
  task automatic drive_edge(input int src, input logic lvl, input logic fsv,
                            input string req);
    item_t it;
    @(negedge clk);
    case (src)
      0: begin int_bclk = lvl; int_fs = fsv; end
      1: begin ck_pin_i = lvl; fs_pin_i = fsv; end
      default: begin tx_bclk = lvl; tx_fs = fsv; end
    endcase
    it.is_launch = (lvl != pol);
    if (!it.is_launch) fs_model = fsv;
    it.fs_exp = fs_model;
    it.cyc = cyc;
    it.req = req;
    q_exp.push_back(it);
    repeat (6) @(negedge clk);
  endtask

  task automatic toggle_unused(input string req);
    @(negedge clk); int_bclk = 1'b1;
    repeat (6) @(negedge clk); int_bclk = 1'b0;
    repeat (6) @(negedge clk);
    chk(q_exp.size() == 0, req, "queue drained", q_exp.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; sync_mode = 0; ckdir = 1; fsdir = 1; pol = 0;
    int_bclk = 0; int_fs = 0; tx_bclk = 0; tx_fs = 0;
    flag0_out = 0; flag1_out = 0; ck_pin_i = 0; fs_pin_i = 0;
    repeat (3) @(negedge clk);
    chk(!launch_stb && !sample_stb && !fs_smp, "R11", "reset outputs",
        {launch_stb, sample_stb, fs_smp}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!flag0_in && !flag1_in && !fs_smp, "R11", "after release",
        {flag0_in, flag1_in, fs_smp}, 0);

    // R4 / R8: async, local sources driving pins
    chk(ck_pin_oe && fs_pin_oe, "R4", "oe async out", {ck_pin_oe, fs_pin_oe}, 3);
    int_bclk = 1; #0.5;
    chk(ck_pin_o == 1, "R4", "ck_pin_o follows int_bclk", ck_pin_o, 1);
    int_bclk = 0; int_fs = 1; #0.5;
    chk(fs_pin_o == 1, "R8", "fs_pin_o follows int_fs", fs_pin_o, 1);
    int_fs = 0;
    // R1 polarity 0, local sources
    drive_edge(0, 1, 1, "R1");
    drive_edge(0, 0, 1, "R1");
    drive_edge(0, 1, 0, "R1");
    drive_edge(0, 0, 0, "R1");
    drive_edge(0, 1, 1, "R1");
    drive_edge(0, 0, 1, "R1");
    // R2 polarity 1
    @(negedge clk); pol = 1;
    drive_edge(0, 1, 0, "R2");
    drive_edge(0, 0, 0, "R2");
    drive_edge(0, 1, 1, "R2");
    drive_edge(0, 0, 1, "R2");
    chk(q_exp.size() == 0, "R2", "queue drained", q_exp.size(), 0);

    // R5 / R8: async, pins as inputs
    @(negedge clk); pol = 0; int_fs = 0; ckdir = 0; fsdir = 0; #0.5;
    chk(!ck_pin_oe && !fs_pin_oe, "R10", "oe released without clock",
        {ck_pin_oe, fs_pin_oe}, 0);
    repeat (4) @(negedge clk);
    drive_edge(1, 1, 0, "R5");
    drive_edge(1, 0, 0, "R8");
    drive_edge(1, 1, 1, "R5");
    drive_edge(1, 0, 1, "R8");
    toggle_unused("R5");
    @(negedge clk); ck_pin_i = 0; fs_pin_i = 0;
    repeat (4) @(negedge clk);

    // R6 / R9: sync, shared clock, clock pin drives flag 0
    sync_mode = 1; ckdir = 1; fsdir = 1; flag0_out = 1; flag1_out = 0; #0.5;
    chk(ck_pin_oe && ck_pin_o == 1, "R6", "ck pin = flag0_out",
        {ck_pin_oe, ck_pin_o}, 3);
    chk(fs_pin_oe && fs_pin_o == 0, "R9", "fs pin = flag1_out",
        {fs_pin_oe, fs_pin_o}, 2);
    flag1_out = 1; #0.5;
    chk(fs_pin_o == 1, "R10", "fs pin follows flag1_out", fs_pin_o, 1);
    repeat (4) @(negedge clk);
    chk(!flag0_in && !flag1_in, "R7", "flags read 0 when outputs",
        {flag0_in, flag1_in}, 0);
    pol = 1;
    drive_edge(2, 1, 1, "R6");
    drive_edge(2, 0, 1, "R9");
    drive_edge(2, 1, 0, "R6");
    drive_edge(2, 0, 0, "R9");
    toggle_unused("R6");

    // R7 / R9: synchronous input flags
    @(negedge clk); ckdir = 0; fsdir = 0; ck_pin_i = 1; fs_pin_i = 1; #0.5;
    chk(!ck_pin_oe && !fs_pin_oe, "R7", "pins released", {ck_pin_oe, fs_pin_oe}, 0);
    @(negedge clk);
    chk(!flag0_in, "R7", "flag0_in after one edge", flag0_in, 0);
    @(negedge clk);
    chk(flag0_in && flag1_in, "R7", "flags after two edges", {flag0_in, flag1_in}, 3);
    ck_pin_i = 0;
    repeat (2) @(negedge clk);
    chk(!flag0_in && flag1_in, "R9", "flag0 clear flag1 held",
        {flag0_in, flag1_in}, 1);
    sync_mode = 0; #0.5;
    chk(!flag1_in, "R9", "flag1_in 0 outside sync mode", flag1_in, 0);
    repeat (6) @(negedge clk);
    chk(q_exp.size() == 0, "R3", "queue empty at end", q_exp.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule